// File: doc/BRIEF.md
# Rotating Per-Task Context Register Bank

This block stands in for the architectural registers of a small 8-bit processor core so that a fixed set of tasks can share the core, each with its own private register values. Five registers are covered: an 8-bit accumulator, an 8-bit index register, a 5-bit condition code, a 5-bit stack pointer and a 12-bit program counter. Each register is a ring with one slot per task. The core only ever reads and writes slot zero, the head. So the core's register behaviour is the same whichever task is running.

A scheduler asks for a target task. The bank then shifts every ring together by one slot per clock, always in the same direction, until the target task's slot is at the head. It then raises a one-cycle done flag. Moving to the next task costs one cycle. The worst case is one cycle fewer than the number of tasks.

A reduced build serves cores that push their other registers onto the stack during an interrupt. In that build only the stack pointer is kept per task. The accumulator, index, condition code and program counter are single shared registers.

Top module: `ctx_ring_bank`

## Requirements
- R1: After reset every register output reads zero, every task's saved values are zero, head_task is 0, and busy and done are low.
- R2: A write strobe (wr_acc, wr_idx, wr_cc, wr_sp, wr_pc) in a cycle with no rotation loads the matching data input into the head slot, visible on the output after that clock edge; a register whose strobe is low keeps its value.
- R3: Each rotation clock advances head_task by exactly one, wrapping from NTASK-1 to 0, and every ring shifts with it so that the outputs then show the saved values of the task now at the head.
- R4: A request accepted while head_task is h and the target is t finishes after (t-h) mod NTASK rotation clocks. busy stays high between those clocks. done is high for exactly one cycle, right after the last rotation edge, with busy low and head_task equal to t. With NTASK=7 the worst case is 6 rotations.
- R5: A request for the task already at the head causes no rotation; done rises after the request edge and the outputs are unchanged.
- R6: The values a task held when it left the head are shown again, unchanged, when it returns to the head, whatever switches happen in between.
- R7: Write strobes have no effect on any task's context in a cycle where a rotation takes place, either while busy or on the edge that accepts a request.
- R8: A request made while busy is ignored: the target and the remaining latency of the running switch are unchanged.
- R9: A request whose target is NTASK or above is ignored: no rotation, no done pulse, outputs unchanged.
- R10: With MODE set to CTX_SP_ONLY only the stack pointer is kept per task. The other four registers are single shared registers whose values do not change across a switch.
- R11: Rotation only ever increments head_task; head_task is stable in any cycle that neither is busy nor accepts a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Switch request strobe from the scheduler |
| sw_task | input | TW | Target task index |
| head_task | output | TW | Task whose context is at the head |
| busy | output | 1 | Rotation in progress |
| done | output | 1 | One-cycle pulse when the head reaches the target |
| wr_acc | input | 1 | Accumulator write strobe |
| acc_d | input | ACC_W | Accumulator write data |
| wr_idx | input | 1 | Index register write strobe |
| idx_d | input | IDX_W | Index register write data |
| wr_cc | input | 1 | Condition code write strobe |
| cc_d | input | CC_W | Condition code write data |
| wr_sp | input | 1 | Stack pointer write strobe |
| sp_d | input | SP_W | Stack pointer write data |
| wr_pc | input | 1 | Program counter write strobe |
| pc_d | input | PC_W | Program counter write data |
| acc_q | output | ACC_W | Head accumulator |
| idx_q | output | IDX_W | Head index register |
| cc_q | output | CC_W | Head condition code |
| sp_q | output | SP_W | Head stack pointer |
| pc_q | output | PC_W | Head program counter |

## Verification
Two seven-task instances, one full and one reduced, get the same stimulus. Every ordered pair of start and target task is tried, which covers zero distance, single steps, the wrap past task 6 and the six-step worst case. The measured latency and the final head tell a correct modular distance apart from an off-by-one or a reversed rotation. Each task's context is seeded with values unique to it and rewritten during the sweep, so a misaligned ring, a leaked write during rotation or a lost slot shows up as a wrong value for some task. Junk writes during rotation, a second request while busy and an out-of-range target check that those inputs are ignored.

// File: rtl/ctx_ring_pkg.sv
// Package: shared mode type and default register widths for the context bank.
// Assumes nothing beyond IEEE 1800-2017.
package ctx_ring_pkg;
    typedef enum logic {
        CTX_FULL    = 1'b0,  // every register kept per task
        CTX_SP_ONLY = 1'b1   // only the stack pointer kept per task
    } ctx_mode_e;

    localparam int DEF_ACC_W = 8;
    localparam int DEF_IDX_W = 8;
    localparam int DEF_CC_W  = 5;
    localparam int DEF_SP_W  = 5;
    localparam int DEF_PC_W  = 12;
endpackage

// File: rtl/ctx_ring_buf.sv
// Module: one register kept as a ring of DEPTH slots, slot 0 being the head.
// On rot every slot takes the value of its successor and the head wraps to
// the tail; otherwise a write strobe loads the head. Assumes DEPTH >= 2.
module ctx_ring_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rot,
    input  logic         wr_en,
    input  logic [W-1:0] wr_d,
    output logic [W-1:0] head_q
);
    logic [W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam int NXT = (i == DEPTH - 1) ? 0 : i + 1;
        if (i == 0) begin : g_head
            // Head slot: shift in the successor, or take a core write.
            always_ff @(posedge clk) begin
                if (!rst_n)     slot[i] <= '0;
                else if (rot)   slot[i] <= slot[NXT];
                else if (wr_en) slot[i] <= wr_d;
            end
        end else begin : g_body
            // Stored slot: only changes when the ring shifts.
            always_ff @(posedge clk) begin
                if (!rst_n)   slot[i] <= '0;
                else if (rot) slot[i] <= slot[NXT];
            end
        end
    end

    assign head_q = slot[0];
endmodule

// File: rtl/ctx_plain_reg.sv
// Module: a single shared register used in the reduced build for registers
// that the core saves on its own stack. Assumes the caller gates wr_en.
module ctx_plain_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_d,
    output logic [W-1:0] q
);
    // Hold value, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_d;
    end
endmodule

// File: rtl/ctx_switch_seq.sv
// Module: switch sequencer. Tracks which task sits at the head, accepts one
// request at a time, issues one rotation per clock until the head matches the
// target and then pulses done. Assumes NTASK >= 2 and a one-way ring.
module ctx_switch_seq #(
    parameter int NTASK = 7,
    parameter int TW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_req,
    input  logic [TW-1:0] sw_task,
    output logic          rotate,
    output logic [TW-1:0] head_task,
    output logic          busy,
    output logic          done
);
    localparam logic [TW:0]   NTASK_EXT = (TW + 1)'(NTASK);
    localparam logic [TW-1:0] LAST      = TW'(NTASK - 1);

    logic [TW-1:0] head_q, tgt_q, tgt_act, head_inc, head_nxt;
    logic          busy_q, done_q, in_range, accept;

    // Request qualification: legal target and no switch already running.
    always_comb begin
        in_range = ({1'b0, sw_task} < NTASK_EXT);
        accept   = sw_req && !busy_q && in_range;
        tgt_act  = busy_q ? tgt_q : sw_task;
    end

    // Next head: one step forward with wrap, only when rotating.
    always_comb begin
        head_inc = (head_q == LAST) ? '0 : head_q + 1'b1;
        rotate   = busy_q || (accept && (sw_task != head_q));
        head_nxt = rotate ? head_inc : head_q;
    end

    // Sequencer state: head index, latched target, busy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tgt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            head_q <= head_nxt;
            if (accept) tgt_q <= sw_task;
            busy_q <= rotate && (head_nxt != tgt_act);
            done_q <= (busy_q || accept) && (head_nxt == tgt_act);
        end
    end

    assign head_task = head_q;
    assign busy      = busy_q;
    assign done      = done_q;
endmodule

// File: rtl/ctx_ring_bank.sv
// Module: top of the per-task context bank. Instantiates the sequencer and
// one ring per kept register; in the reduced build the registers other than
// the stack pointer are single shared registers. Core writes are dropped in
// any cycle that rotates. Assumes 2 <= NTASK.
module ctx_ring_bank #(
    parameter int                    NTASK = 7,
    parameter ctx_ring_pkg::ctx_mode_e MODE = ctx_ring_pkg::CTX_FULL,
    parameter int                    ACC_W = ctx_ring_pkg::DEF_ACC_W,
    parameter int                    IDX_W = ctx_ring_pkg::DEF_IDX_W,
    parameter int                    CC_W  = ctx_ring_pkg::DEF_CC_W,
    parameter int                    SP_W  = ctx_ring_pkg::DEF_SP_W,
    parameter int                    PC_W  = ctx_ring_pkg::DEF_PC_W,
    localparam int                   TW    = (NTASK > 1) ? $clog2(NTASK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic [TW-1:0]    sw_task,
    output logic [TW-1:0]    head_task,
    output logic             busy,
    output logic             done,
    input  logic             wr_acc,
    input  logic [ACC_W-1:0] acc_d,
    input  logic             wr_idx,
    input  logic [IDX_W-1:0] idx_d,
    input  logic             wr_cc,
    input  logic [CC_W-1:0]  cc_d,
    input  logic             wr_sp,
    input  logic [SP_W-1:0]  sp_d,
    input  logic             wr_pc,
    input  logic [PC_W-1:0]  pc_d,
    output logic [ACC_W-1:0] acc_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [CC_W-1:0]  cc_q,
    output logic [SP_W-1:0]  sp_q,
    output logic [PC_W-1:0]  pc_q
);
    logic rotate;
    logic acc_we, idx_we, cc_we, sp_we, pc_we;

    ctx_switch_seq #(.NTASK(NTASK), .TW(TW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .sw_task   (sw_task),
        .rotate    (rotate),
        .head_task (head_task),
        .busy      (busy),
        .done      (done)
    );

    // Write gating: a rotating cycle never takes a core write.
    always_comb begin
        acc_we = wr_acc && !rotate;
        idx_we = wr_idx && !rotate;
        cc_we  = wr_cc  && !rotate;
        sp_we  = wr_sp  && !rotate;
        pc_we  = wr_pc  && !rotate;
    end

    // Stack pointer is always kept per task.
    ctx_ring_buf #(.W(SP_W), .DEPTH(NTASK)) sp_ring_i (
        .clk(clk), .rst_n(rst_n), .rot(rotate), .wr_en(sp_we), .wr_d(sp_d), .head_q(sp_q)
    );

    if (MODE == ctx_ring_pkg::CTX_FULL) begin : g_full
        ctx_ring_buf #(.W(ACC_W), .DEPTH(NTASK)) acc_ring_i (
            .clk(clk), .rst_n(rst_n), .rot(rotate), .wr_en(acc_we), .wr_d(acc_d), .head_q(acc_q)
        );
        ctx_ring_buf #(.W(IDX_W), .DEPTH(NTASK)) idx_ring_i (
            .clk(clk), .rst_n(rst_n), .rot(rotate), .wr_en(idx_we), .wr_d(idx_d), .head_q(idx_q)
        );
        ctx_ring_buf #(.W(CC_W), .DEPTH(NTASK)) cc_ring_i (
            .clk(clk), .rst_n(rst_n), .rot(rotate), .wr_en(cc_we), .wr_d(cc_d), .head_q(cc_q)
        );
        ctx_ring_buf #(.W(PC_W), .DEPTH(NTASK)) pc_ring_i (
            .clk(clk), .rst_n(rst_n), .rot(rotate), .wr_en(pc_we), .wr_d(pc_d), .head_q(pc_q)
        );
    end else begin : g_sp_only
        ctx_plain_reg #(.W(ACC_W)) acc_reg_i (
            .clk(clk), .rst_n(rst_n), .wr_en(acc_we), .wr_d(acc_d), .q(acc_q)
        );
        ctx_plain_reg #(.W(IDX_W)) idx_reg_i (
            .clk(clk), .rst_n(rst_n), .wr_en(idx_we), .wr_d(idx_d), .q(idx_q)
        );
        ctx_plain_reg #(.W(CC_W)) cc_reg_i (
            .clk(clk), .rst_n(rst_n), .wr_en(cc_we), .wr_d(cc_d), .q(cc_q)
        );
        ctx_plain_reg #(.W(PC_W)) pc_reg_i (
            .clk(clk), .rst_n(rst_n), .wr_en(pc_we), .wr_d(pc_d), .q(pc_q)
        );
    end
endmodule

// File: rtl/ctx_ring_chk.sv
// Module: property checker for ctx_ring_bank, attached with bind below.
// Observes ports only; assumes the same NTASK and widths as the bank.
module ctx_ring_chk #(
    parameter int NTASK = 7,
    parameter int TW    = 3,
    parameter int ACC_W = 8,
    parameter int SP_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_req,
    input logic [TW-1:0]    head_task,
    input logic             busy,
    input logic             done,
    input logic             wr_acc,
    input logic [ACC_W-1:0] acc_d,
    input logic [ACC_W-1:0] acc_q,
    input logic             wr_sp,
    input logic [SP_W-1:0]  sp_d,
    input logic [SP_W-1:0]  sp_q
);
    localparam logic [TW:0]   NTASK_EXT = (TW + 1)'(NTASK);
    localparam logic [TW-1:0] LAST      = TW'(NTASK - 1);

    assert_head_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, head_task} < NTASK_EXT);

    assert_busy_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> head_task == (($past(head_task) == LAST) ? '0 : $past(head_task) + 1'b1));

    assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_idle_head_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sw_req) |=> $stable(head_task));

    assert_acc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sw_req && wr_acc) |=> acc_q == $past(acc_d));

    assert_sp_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sw_req && wr_sp) |=> sp_q == $past(sp_d));

    assert_sp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sw_req && !wr_sp) |=> $stable(sp_q));
endmodule

bind ctx_ring_bank ctx_ring_chk #(
    .NTASK(NTASK), .TW(TW), .ACC_W(ACC_W), .SP_W(SP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .head_task(head_task),
    .busy(busy), .done(done), .wr_acc(wr_acc), .acc_d(acc_d), .acc_q(acc_q),
    .wr_sp(wr_sp), .sp_d(sp_d), .sp_q(sp_q)
);

// File: tb/ctx_ring_bank_tb_top.sv
// Bench: a full and a reduced seven-task bank with shared stimulus; every
// start/target pair is swept, with models of each task's context kept here.
module ctx_ring_bank_tb_top;
    localparam int N = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_req = 1'b0;
    logic [2:0] sw_task = '0;
    logic       wr_acc = 0, wr_idx = 0, wr_cc = 0, wr_sp = 0, wr_pc = 0;
    logic [7:0] acc_d = '0, idx_d = '0;
    logic [4:0] cc_d = '0, sp_d = '0;
    logic [11:0] pc_d = '0;

    logic [2:0] head_f, head_r;
    logic busy_f, busy_r, done_f, done_r;
    logic [7:0] acc_f, idx_f, acc_r, idx_r;
    logic [4:0] cc_f, sp_f, cc_r, sp_r;
    logic [11:0] pc_f, pc_r;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Models: per-task full context, reduced-build shared registers.
    logic [7:0]  m_acc [N];
    logic [7:0]  m_idx [N];
    logic [4:0]  m_cc  [N];
    logic [4:0]  m_sp  [N];
    logic [11:0] m_pc  [N];
    logic [7:0]  s_acc = '0, s_idx = '0;
    logic [4:0]  s_cc = '0;
    logic [11:0] s_pc = '0;
    int m_head = 0;

    always #10 clk = ~clk;  // 50 MHz

    ctx_ring_bank #(.NTASK(N), .MODE(ctx_ring_pkg::CTX_FULL)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_task(sw_task),
        .head_task(head_f), .busy(busy_f), .done(done_f),
        .wr_acc(wr_acc), .acc_d(acc_d), .wr_idx(wr_idx), .idx_d(idx_d),
        .wr_cc(wr_cc), .cc_d(cc_d), .wr_sp(wr_sp), .sp_d(sp_d),
        .wr_pc(wr_pc), .pc_d(pc_d),
        .acc_q(acc_f), .idx_q(idx_f), .cc_q(cc_f), .sp_q(sp_f), .pc_q(pc_f)
    );

    ctx_ring_bank #(.NTASK(N), .MODE(ctx_ring_pkg::CTX_SP_ONLY)) dut_r_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_task(sw_task),
        .head_task(head_r), .busy(busy_r), .done(done_r),
        .wr_acc(wr_acc), .acc_d(acc_d), .wr_idx(wr_idx), .idx_d(idx_d),
        .wr_cc(wr_cc), .cc_d(cc_d), .wr_sp(wr_sp), .sp_d(sp_d),
        .wr_pc(wr_pc), .pc_d(pc_d),
        .acc_q(acc_r), .idx_q(idx_r), .cc_q(cc_r), .sp_q(sp_r), .pc_q(pc_r)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare both instances against the models for task k.
    task automatic check_ctx(input string req, input int k);
        check({req, " acc"}, acc_f, m_acc[k]);
        check({req, " idx"}, idx_f, m_idx[k]);
        check({req, " cc"},  cc_f,  m_cc[k]);
        check({req, " sp"},  sp_f,  m_sp[k]);
        check({req, " pc"},  pc_f,  m_pc[k]);
        check({req, "/R10 red sp"},  sp_r,  m_sp[k]);
        check("R10 red acc shared", acc_r, s_acc);
        check("R10 red idx shared", idx_r, s_idx);
        check("R10 red cc shared",  cc_r,  s_cc);
        check("R10 red pc shared",  pc_r,  s_pc);
    endtask

    task automatic drive_wr(input bit en, input int seed);
        {wr_acc, wr_idx, wr_cc, wr_sp, wr_pc} = en ? 5'b11111 : 5'b00000;
        acc_d = 8'((seed * 29 + 3) & 255);
        idx_d = 8'((seed * 53 + 17) & 255);
        cc_d  = 5'((seed * 7 + 1) & 31);
        sp_d  = 5'((seed * 11 + 5) & 31);
        pc_d  = 12'((seed * 389 + 77) & 4095);
    endtask

    // Full write of all five registers for task k at the head.
    task automatic write_ctx(input int seed);
        @(negedge clk);
        drive_wr(1, seed);
        @(negedge clk);
        m_acc[m_head] = acc_d; m_idx[m_head] = idx_d; m_cc[m_head] = cc_d;
        m_sp[m_head] = sp_d;   m_pc[m_head] = pc_d;
        s_acc = acc_d; s_idx = idx_d; s_cc = cc_d; s_pc = pc_d;
        drive_wr(0, 0);
        check_ctx("R2 write", m_head);
    endtask

    // Switch to task t with junk writes during rotation and a stray request.
    task automatic switch_to(input int t);
        int d, exp_edges, edges, prev;
        d = (t - m_head + N) % N;
        exp_edges = (d == 0) ? 1 : d;
        @(negedge clk);
        sw_req = 1'b1; sw_task = 3'(t);
        if (d > 0) drive_wr(1, 200 + t);   // R7: accept-edge write must drop
        prev = m_head;
        @(negedge clk);
        sw_req = 1'b0;
        edges = 1;
        while (!done_f && edges < 20) begin
            check("R3 step", head_f, (prev + 1) % N);
            prev = (prev + 1) % N;
            if (edges == 1 && d >= 2) begin
                sw_req = 1'b1; sw_task = 3'((t + 3) % N);  // R8: ignored
            end
            drive_wr(1, 300 + edges);                      // R7: busy write drops
            @(negedge clk);
            sw_req = 1'b0;
            edges++;
        end
        drive_wr(0, 0);
        check(d == 0 ? "R5 latency" : "R4 latency", edges, exp_edges);
        check("R4 head", head_f, t);
        check("R4 busy low", busy_f, 0);
        check("R10 red head", head_r, t);
        check("R10 red done", done_r, 1);
        m_head = t;
        check_ctx("R6/R7 context", t);
        @(negedge clk);
        check("R4 done pulse", done_f, 0);
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            m_acc[k] = '0; m_idx[k] = '0; m_cc[k] = '0; m_sp[k] = '0; m_pc[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 head", head_f, 0);
        check("R1 busy", busy_f, 0);
        check("R1 done", done_f, 0);
        check_ctx("R1 reset", 0);

        // R1: every task's context is zero out of reset.
        for (int k = 1; k < N; k++) switch_to(k);
        switch_to(0);

        // Seed each task with distinct values.
        for (int k = 0; k < N; k++) begin
            switch_to(k);
            write_ctx(k + 1);
        end

        // R2: partial write touches only the strobed register.
        @(negedge clk);
        wr_acc = 1'b1; acc_d = 8'hA5;
        @(negedge clk);
        wr_acc = 1'b0;
        m_acc[m_head] = 8'hA5; s_acc = 8'hA5;
        check_ctx("R2 partial", m_head);

        // Sweep every start/target pair (R3, R4, R5, R6, R11).
        for (int h = 0; h < N; h++) begin
            for (int t = 0; t < N; t++) begin
                switch_to(h);
                switch_to(t);
                if ((h + t) % 3 == 0) write_ctx(40 + h * N + t);
            end
        end

        // R9: out-of-range target is ignored.
        @(negedge clk);
        sw_req = 1'b1; sw_task = 3'd7;
        @(negedge clk);
        sw_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R9 no done", done_f, 0);
            check("R9 no busy", busy_f, 0);
            check("R9 head", head_f, m_head);
            @(negedge clk);
        end
        check_ctx("R9 context", m_head);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule